// File: doc/BRIEF.md
# Serial EEPROM Byte Writer with Completion Polling

This block is a two-wire bus master that stores one byte into a small serial EEPROM and then waits for the memory to finish its internal programming. It takes a command made of a word address and a data byte. It drives START, a write-mode control byte, the address, the data and STOP onto open-drain clock and data lines. The memory begins its self-timed write at that STOP. The block then probes the memory again and again, each probe being START, the same control byte and STOP, and stops probing at the first probe the memory acknowledges.

The block never waits a fixed programming delay. A missing acknowledge on a probe is read as "still busy" and leads to another probe. An acknowledged probe ends the command with a one-cycle completion pulse. Two faults end a command early. A refused byte during the write sets an error flag. A probe budget that runs out sets a timeout flag. Bit timing comes from a divider that splits each bit into four equal quarters. Clock stretching, arbitration and reads are not handled.

Top module: `eeprom_poll_master`

## Requirements
- R1: After reset and whenever the block is idle, both line drivers are released (scl_oe_o=0, sda_oe_o=0), and busy_o, done_o, err_o and timeout_o are low.
- R2: A command sends START, then the control byte {1010, SEL_BITS, 0} (0xA0 by default), then the word address byte, then the data byte, then STOP. Bytes go out MSB first. Every byte is followed by a ninth clock with SDA released, and SDA low on that clock counts as an acknowledge.
- R3: SDA changes only while SCL is low. The two exceptions are a falling SDA with SCL high, which is only START, and a rising SDA with SCL high, which is only STOP.
- R4: After the write's STOP, the block issues polls of START, the control byte and STOP. A refused poll is followed by another poll. An acknowledged poll ends the command with a done_o pulse exactly one cycle wide, and busy_o falls in that same cycle.
- R5: A refused control, address or data byte during the write ends the command at once with STOP and sets err_o. No later byte is sent and no poll follows.
- R6: After MAX_POLLS consecutive refused polls the block sends STOP, sets timeout_o and returns to idle without a further START.
- R7: start_i is ignored while busy_o is high.
- R8: err_o and timeout_o stay set until the next accepted command, which clears them in the cycle it is taken. busy_o is high from that cycle until the command ends. err_o and timeout_o are never set together, and busy_o falls only together with done_o, err_o or timeout_o.
- R9: Each bit on the bus lasts 4*QTR_CYCLES clock cycles, rising SCL edge to rising SCL edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Command request, taken only when idle |
| waddr_i | input | 8 | Word address to write |
| wdata_i | input | 8 | Data byte to write |
| sda_i | input | 1 | Sensed level of the data line |
| scl_oe_o | output | 1 | 1 pulls the clock line low |
| sda_oe_o | output | 1 | 1 pulls the data line low |
| busy_o | output | 1 | Command in progress |
| done_o | output | 1 | One-cycle pulse when a poll is acknowledged |
| err_o | output | 1 | Write byte was refused |
| timeout_o | output | 1 | Poll budget was used up |

## Verification
A bus-level memory model in the bench is driven with commands that differ in how many polls the memory refuses. These are none, a few, one less than the budget (done on the last allowed poll) and exactly the budget (timeout), which together mark where completion turns into timeout. Separate commands have the control, address or data byte refused, which shows where the abort happens and that no probing follows. An address with its upper nibble set shows that the full byte is sent on the bus. A second request raised in the middle of a command shows that it is not taken.

// File: rtl/eeprom_poll_pkg.sv
package eeprom_poll_pkg;
  typedef enum logic [1:0] {SYM_IDLE, SYM_START, SYM_BIT, SYM_STOP} sym_e;
  typedef enum logic [1:0] {JOB_CTRL, JOB_ADDR, JOB_DATA, JOB_POLL} job_e;
  typedef enum logic [2:0] {END_ABORT, END_WRITTEN, END_RETRY, END_DONE, END_TIMEOUT} end_e;
  localparam logic [3:0] DEV_CODE = 4'b1010;
endpackage

// File: rtl/eeprom_poll_tick.sv
module eeprom_poll_tick #(
  parameter int QTR_CYCLES = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  localparam int CW = (QTR_CYCLES > 1) ? $clog2(QTR_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(QTR_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (!run_i)       cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                   cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = run_i && (cnt_q == LAST);
endmodule

// File: rtl/eeprom_poll_line.sv
module eeprom_poll_line
  import eeprom_poll_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  sym_e       sym_i,
  input  logic [1:0] qtr_i,
  input  logic       bit_i,   // 1 = release SDA
  output logic       scl_oe_o,
  output logic       sda_oe_o
);
  logic scl_low_d, sda_low_d;

  always_comb begin
    scl_low_d = 1'b0;
    sda_low_d = 1'b0;
    unique case (sym_i)
      SYM_START: begin
        sda_low_d = qtr_i[1];
        scl_low_d = (qtr_i == 2'd3);
      end
      SYM_BIT: begin
        sda_low_d = !bit_i;
        scl_low_d = (qtr_i == 2'd0) || (qtr_i == 2'd3);
      end
      SYM_STOP: begin
        sda_low_d = !qtr_i[1];
        scl_low_d = (qtr_i == 2'd0);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_oe_o <= 1'b0;
      sda_oe_o <= 1'b0;
    end else begin
      scl_oe_o <= scl_low_d;
      sda_oe_o <= sda_low_d;
    end
  end
endmodule

// File: rtl/eeprom_poll_budget.sv
module eeprom_poll_budget #(
  parameter int MAX_POLLS = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic miss_i,
  output logic last_o
);
  localparam int CW = $clog2(MAX_POLLS + 1);

  logic [CW-1:0] miss_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      miss_q <= '0;
    else if (clear_i) miss_q <= '0;
    else if (miss_i)  miss_q <= miss_q + 1'b1;
  end

  assign last_o = (miss_q == CW'(MAX_POLLS - 1));
endmodule

// File: rtl/eeprom_poll_master.sv
module eeprom_poll_master
  import eeprom_poll_pkg::*;
#(
  parameter int          QTR_CYCLES = 4,
  parameter int          MAX_POLLS  = 8,
  parameter logic [2:0]  SEL_BITS   = 3'b000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic [7:0] waddr_i,
  input  logic [7:0] wdata_i,
  input  logic       sda_i,
  output logic       scl_oe_o,
  output logic       sda_oe_o,
  output logic       busy_o,
  output logic       done_o,
  output logic       err_o,
  output logic       timeout_o
);
  localparam int BYTE_W = 8;
  localparam int BIT_CW = $clog2(BYTE_W + 1);
  localparam logic [BIT_CW-1:0] ACK_SLOT = BIT_CW'(BYTE_W);
  localparam logic [BYTE_W-1:0] CTRL_WR  = {DEV_CODE, SEL_BITS, 1'b0};

  sym_e              sym_q;
  job_e              job_q;
  end_e              end_q;
  logic [1:0]        qtr_q;
  logic [BIT_CW-1:0] bit_q;
  logic [BYTE_W-1:0] shreg_q, addr_q, data_q;
  logic              ack_q, done_q, err_q, tmo_q;
  logic              tick, accept, ack_end, poll_miss, last_poll, tx_bit;

  assign accept    = (sym_q == SYM_IDLE) && start_i;
  assign ack_end   = tick && (sym_q == SYM_BIT) && (qtr_q == 2'd3) && (bit_q == ACK_SLOT);
  assign poll_miss = ack_end && (job_q == JOB_POLL) && !ack_q;
  assign tx_bit    = (bit_q == ACK_SLOT) ? 1'b1 : shreg_q[BYTE_W-1];

  eeprom_poll_tick #(.QTR_CYCLES(QTR_CYCLES)) u_tick (
    .clk_i, .rst_ni, .run_i(sym_q != SYM_IDLE), .tick_o(tick)
  );

  eeprom_poll_budget #(.MAX_POLLS(MAX_POLLS)) u_budget (
    .clk_i, .rst_ni, .clear_i(accept), .miss_i(poll_miss), .last_o(last_poll)
  );

  eeprom_poll_line u_line (
    .clk_i, .rst_ni, .sym_i(sym_q), .qtr_i(qtr_q), .bit_i(tx_bit),
    .scl_oe_o, .sda_oe_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sym_q   <= SYM_IDLE;
      job_q   <= JOB_CTRL;
      end_q   <= END_ABORT;
      qtr_q   <= '0;
      bit_q   <= '0;
      shreg_q <= '0;
      addr_q  <= '0;
      data_q  <= '0;
      ack_q   <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      tmo_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        addr_q  <= waddr_i;
        data_q  <= wdata_i;
        shreg_q <= CTRL_WR;
        job_q   <= JOB_CTRL;
        sym_q   <= SYM_START;
        qtr_q   <= '0;
        err_q   <= 1'b0;
        tmo_q   <= 1'b0;
      end else if (tick) begin
        qtr_q <= qtr_q + 2'd1;
        if (sym_q == SYM_START && qtr_q == 2'd3) begin
          sym_q <= SYM_BIT;
          bit_q <= '0;
        end
        if (sym_q == SYM_BIT) begin
          if (qtr_q == 2'd2 && bit_q == ACK_SLOT) ack_q <= !sda_i;
          if (qtr_q == 2'd3) begin
            if (bit_q != ACK_SLOT) begin
              bit_q   <= bit_q + 1'b1;
              shreg_q <= {shreg_q[BYTE_W-2:0], 1'b1};
            end else begin
              bit_q <= '0;
              // refused write byte aborts; refused poll retries until budget spent
              unique case (job_q)
                JOB_CTRL: if (ack_q) begin job_q <= JOB_ADDR; shreg_q <= addr_q; end
                          else begin sym_q <= SYM_STOP; end_q <= END_ABORT; end
                JOB_ADDR: if (ack_q) begin job_q <= JOB_DATA; shreg_q <= data_q; end
                          else begin sym_q <= SYM_STOP; end_q <= END_ABORT; end
                JOB_DATA: begin
                  sym_q <= SYM_STOP;
                  end_q <= ack_q ? END_WRITTEN : END_ABORT;
                end
                default: begin
                  sym_q <= SYM_STOP;
                  end_q <= ack_q ? END_DONE : (last_poll ? END_TIMEOUT : END_RETRY);
                end
              endcase
            end
          end
        end
        if (sym_q == SYM_STOP && qtr_q == 2'd3) begin
          unique case (end_q)
            END_WRITTEN, END_RETRY: begin
              sym_q   <= SYM_START;
              job_q   <= JOB_POLL;
              shreg_q <= CTRL_WR;
            end
            END_DONE:    begin sym_q <= SYM_IDLE; done_q <= 1'b1; end
            END_TIMEOUT: begin sym_q <= SYM_IDLE; tmo_q  <= 1'b1; end
            default:     begin sym_q <= SYM_IDLE; err_q  <= 1'b1; end
          endcase
        end
      end
    end
  end

  assign busy_o    = (sym_q != SYM_IDLE);
  assign done_o    = done_q;
  assign err_o     = err_q;
  assign timeout_o = tmo_q;
endmodule

// File: rtl/eeprom_poll_checker.sv
module eeprom_poll_checker
  import eeprom_poll_pkg::*;
(
  input logic clk_i,
  input logic rst_ni,
  input logic scl_oe_i,
  input logic sda_oe_i,
  input logic busy_i,
  input logic done_i,
  input logic err_i,
  input logic tmo_i,
  input sym_e sym_i
);
  assert_idle_released_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> (!scl_oe_i && !sda_oe_i));

  assert_sda_fall_start_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(scl_oe_i) && !scl_oe_i && $rose(sda_oe_i)) |-> ($past(sym_i) == SYM_START));

  assert_sda_rise_stop_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(scl_oe_i) && !scl_oe_i && $fell(sda_oe_i)) |-> ($past(sym_i) == SYM_STOP));

  assert_done_one_cycle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> !done_i);

  assert_done_idle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> !busy_i);

  assert_flags_exclusive_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(err_i && tmo_i));

  assert_busy_end_reason_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_i) |-> (done_i || err_i || tmo_i));
endmodule

bind eeprom_poll_master eeprom_poll_checker u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .scl_oe_i (scl_oe_o),
  .sda_oe_i (sda_oe_o),
  .busy_i   (busy_o),
  .done_i   (done_o),
  .err_i    (err_o),
  .tmo_i    (timeout_o),
  .sym_i    (sym_q)
);

// File: tb/eeprom_poll_master_test.sv
module eeprom_poll_master_test;
  localparam int QTR  = 4;
  localparam int MAXP = 8;
  localparam int BITP = 4 * QTR;

  typedef struct packed {
    logic [7:0] addr;
    logic [7:0] data;
    logic [1:0] nack_at;  // 0 ctrl, 1 addr, 2 data, 3 none
    logic [3:0] busy_n;   // polls refused after the write
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{8'h03, 8'h5A, 2'd3, 4'd0},
    '{8'h0F, 8'hA5, 2'd3, 4'd3},
    '{8'h07, 8'h00, 2'd3, 4'd7},
    '{8'h02, 8'hFF, 2'd3, 4'd8},
    '{8'h05, 8'h3C, 2'd1, 4'd0},
    '{8'h09, 8'hC3, 2'd2, 4'd0},
    '{8'h0A, 8'h81, 2'd0, 4'd0},
    '{8'h1B, 8'h66, 2'd3, 4'd1}
  };

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, sda_in;
  logic [7:0] waddr = '0, wdata = '0;
  logic scl_oe, sda_oe, busy, done, err, tmo;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  eeprom_poll_master #(.QTR_CYCLES(QTR), .MAX_POLLS(MAXP)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .waddr_i(waddr), .wdata_i(wdata),
    .sda_i(sda_in), .scl_oe_o(scl_oe), .sda_oe_o(sda_oe), .busy_o(busy),
    .done_o(done), .err_o(err), .timeout_o(tmo)
  );

  // memory model on the bus
  logic m_pull = 1'b0;
  wire scl_line = !scl_oe;
  wire sda_line = !(sda_oe || m_pull);
  assign sda_in = sda_line;

  logic [7:0] m_mem [16];
  logic [7:0] m_rx [3];
  logic [7:0] m_sh;
  logic [1:0] m_nack_at = 2'd3;
  int m_busy_n = 0, m_busy_left, m_bitcnt, m_byte_idx, m_starts, m_stops, m_bytes;
  int m_polls, m_done_cnt, m_per_bad, m_cyc = 0, m_last_rise;
  bit m_in_ack, m_written, m_nacked, prev_scl = 1, prev_sda = 1, tb_clear = 0;

  always @(negedge clk) begin
    bit ack;
    m_cyc++;
    if (tb_clear) begin
      m_busy_left = 0; m_bitcnt = 0; m_byte_idx = 0; m_starts = 0; m_stops = 0;
      m_bytes = 0; m_polls = 0; m_done_cnt = 0; m_per_bad = 0; m_in_ack = 0;
      m_written = 0; m_nacked = 0; m_pull = 0;
      for (int i = 0; i < 3; i++) m_rx[i] = 8'h00;
    end
    if (done) m_done_cnt++;
    if (scl_line && prev_scl && prev_sda && !sda_line) begin
      m_starts++; m_byte_idx = 0; m_bitcnt = 0; m_in_ack = 0; m_pull = 0;
      if (m_written) m_polls++;
    end else if (scl_line && prev_scl && !prev_sda && sda_line) begin
      m_stops++;
      if (!m_written && m_byte_idx == 3 && !m_nacked) begin
        m_mem[m_rx[1][3:0]] = m_rx[2];
        m_written = 1;
        m_busy_left = m_busy_n;
      end
    end else if (scl_line && !prev_scl) begin
      if (m_bitcnt > 0 && (m_cyc - m_last_rise) != BITP) m_per_bad++;
      m_last_rise = m_cyc;
      if (!m_in_ack) begin m_sh = {m_sh[6:0], sda_line}; m_bitcnt++; end
    end else if (!scl_line && prev_scl) begin
      if (m_in_ack) begin
        m_in_ack = 0; m_pull = 0;
      end else if (m_bitcnt == 8) begin
        if (!m_written && m_byte_idx < 3) m_rx[m_byte_idx] = m_sh;
        case (m_byte_idx)
          0: begin
            ack = (m_sh == 8'hA0) && (m_busy_left == 0) && !(m_nack_at == 2'd0 && !m_written);
            if (m_busy_left > 0) m_busy_left--;
          end
          1: ack = (m_nack_at != 2'd1);
          2: ack = (m_nack_at != 2'd2);
          default: ack = 0;
        endcase
        if (!ack) m_nacked = 1;
        m_in_ack = 1; m_pull = ack; m_bitcnt = 0; m_byte_idx++; m_bytes++;
      end
    end
    prev_scl = scl_line;
    prev_sda = sda_line;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_model();
    @(posedge clk); tb_clear = 1;
    @(posedge clk); tb_clear = 0;
  endtask

  task automatic wait_idle();
    int n = 0;
    while (busy && n < 40000) begin @(negedge clk); n++; end
    check(!busy, "R4 command ends", busy, 0);
    repeat (3) @(negedge clk);
  endtask

  task automatic run_vec(input vec_t v);
    int polls, wbytes;
    bit exp_done, exp_err, exp_tmo;
    logic [7:0] exp_mem;
    exp_err  = (v.nack_at != 2'd3);
    exp_done = !exp_err && (int'(v.busy_n) < MAXP);
    exp_tmo  = !exp_err && !exp_done;
    polls    = exp_err ? 0 : (exp_done ? int'(v.busy_n) + 1 : MAXP);
    wbytes   = (v.nack_at == 2'd0) ? 1 : (v.nack_at == 2'd1) ? 2 : 3;
    exp_mem  = exp_err ? m_mem[v.addr[3:0]] : v.data;
    m_nack_at = v.nack_at; m_busy_n = int'(v.busy_n);
    clear_model();
    @(negedge clk); start = 1; waddr = v.addr; wdata = v.data;
    @(negedge clk); start = 0;
    check(busy && !err && !tmo, "R8 busy set and flags cleared on accept", {busy, err, tmo}, 3'b100);
    wait_idle();
    check(err == exp_err, "R5 err_o", err, exp_err);
    check(tmo == exp_tmo, "R6 timeout_o", tmo, exp_tmo);
    check(m_done_cnt == int'(exp_done), "R4 done pulse count", m_done_cnt, int'(exp_done));
    check(m_polls == polls, "R4 R6 poll count", m_polls, polls);
    check(m_starts == 1 + polls, "R2 START count", m_starts, 1 + polls);
    check(m_stops == m_starts, "R2 STOP per START", m_stops, m_starts);
    check(m_bytes == wbytes + polls, "R5 bytes on bus", m_bytes, wbytes + polls);
    check(m_rx[0] == 8'hA0, "R2 control byte", m_rx[0], 8'hA0);
    if (v.nack_at != 2'd0) check(m_rx[1] == v.addr, "R2 address byte", m_rx[1], v.addr);
    if (v.nack_at >= 2'd2) check(m_rx[2] == v.data, "R2 data byte", m_rx[2], v.data);
    check(m_mem[v.addr[3:0]] == exp_mem, "R2 R5 stored byte", m_mem[v.addr[3:0]], exp_mem);
    check(m_per_bad == 0, "R9 bit period", m_per_bad, 0);
    check(!scl_oe && !sda_oe && !done, "R1 lines released when idle", {scl_oe, sda_oe, done}, 0);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) m_mem[i] = 8'hF0 ^ 8'(i);
    repeat (3) @(negedge clk);
    check(!scl_oe && !sda_oe && !busy && !done && !err && !tmo, "R1 reset state",
          {scl_oe, sda_oe, busy, done, err, tmo}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    check(!busy && !scl_oe && !sda_oe, "R1 idle after reset", {busy, scl_oe, sda_oe}, 0);

    for (int k = 0; k < 8; k++) run_vec(VECS[k]);

    // R7: second request during a command is not taken
    begin
      logic [7:0] keep6;
      keep6 = m_mem[6];
      m_nack_at = 2'd3; m_busy_n = 0;
      clear_model();
      @(negedge clk); start = 1; waddr = 8'h04; wdata = 8'h11;
      @(negedge clk); start = 0;
      repeat (60) @(negedge clk);
      start = 1; waddr = 8'h06; wdata = 8'h22;
      @(negedge clk); start = 0;
      wait_idle();
      check(m_mem[4] == 8'h11, "R7 first command stored", m_mem[4], 8'h11);
      check(m_mem[6] == keep6, "R7 second request ignored", m_mem[6], keep6);
      check(m_starts == 2, "R7 no extra START", m_starts, 2);
      repeat (20) @(negedge clk);
      check(!busy, "R7 no command queued", busy, 0);
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule